// File: doc/BRIEF.md
# Erasure-Learning Syndrome Corrector

This block sits on the read path of a memory whose words carry parity-check bits. For each word it reads, it recomputes the check bits from the data bits and XORs them with the stored check bits to form a syndrome. It keeps a small register file of bit positions that are already known to fail (erasures). Next to that file it holds the syndrome of every combination of those positions. A syndrome that equals one stored combination tells the block exactly which erased bits are wrong in this word. Those bits are inverted, and the result comes out one cycle after the read strobe.

A nonzero syndrome that matches no stored combination means a bit position has failed that the block has not seen before. The block then goes busy. It holds the word and walks the columns of the parity-check matrix, one per cycle, looking for the column equal to the syndrome. When it finds one, it records that position as a new erasure and extends the combination table one entry per cycle. It then releases the corrected word. When no column matches, it releases the word as uncorrectable and learns nothing. Once as many erasures are stored as the code can resolve (distance minus one), a full flag rises. From then on, any unmatched nonzero syndrome is reported as uncorrectable straight away.

The check matrix columns for the data bits are a parameter. The column of check bit j is the unit vector j.

Top module: `ers_decoder`

## Requirements
- R1: The syndrome is the check bits recomputed from `rd_data` XOR `rd_chk`. Check bit j is the parity of the data bits whose matrix column has bit j set. The default data columns for bits 0..7 are 07, 0B, 0D, 0E, 13, 15, 16, 19 (hex, 5 bits). Codeword position p < 8 is data bit p. Position p >= 8 is check bit p-8, with column 1<<(p-8).
- R2: A read with an all-zero syndrome gives, one cycle after the strobe, `out_valid`=1 and `out_data` equal to the data read, with `out_fixed`=0 and `out_uncorr`=0.
- R3: A read whose syndrome equals the XOR of the columns of a nonempty subset of the stored erasures gives, one cycle after the strobe, the data with the data bits of that subset inverted and `out_fixed`=1. When several subsets match, the one with the lowest slot bitmask wins. Slot i holds the i-th position learned.
- R4: When the table is not full and an unmatched nonzero syndrome equals one column, `busy` is 1 from the cycle after the strobe. That position is stored as a new erasure. When `busy` falls, the word comes out in the same cycle with that bit inverted (if it is a data bit) and `out_fixed`=1. Any later read with the same error is then a one-cycle correction.
- R5: When the table is not full and an unmatched nonzero syndrome equals no column, the word comes out unchanged with `out_uncorr`=1 when `busy` falls. No erasure is added, so `full` and later results behave as if that read had not happened.
- R6: The table holds MAX_ERAS (default 3) positions. `full` rises once that many are stored and stays high until reset. While `full` is high, an unmatched nonzero syndrome gives the data unchanged with `out_uncorr`=1 one cycle after the strobe, and `busy` stays 0.
- R7: A read strobe while `busy` is 1 is ignored. Each accepted read yields exactly one `out_valid` pulse of one cycle, and `out_fixed` and `out_uncorr` are never both 1.
- R8: After reset, `out_valid`, `busy` and `full` are 0 and no erasures are stored.
- R9: With the table full, every one of the 2^MAX_ERAS error patterns confined to the stored positions is corrected within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read strobe, one cycle per word |
| rd_data | input | DATA_W | Data bits of the word read |
| rd_chk | input | CHK_W | Stored check bits of the word read |
| out_valid | output | 1 | One-cycle pulse marking a result |
| out_data | output | DATA_W | Corrected (or unchanged) data |
| out_fixed | output | 1 | Result had bits inverted |
| out_uncorr | output | 1 | Result could not be corrected |
| busy | output | 1 | A new erasure is being located or learned; reads are ignored |
| full | output | 1 | Erasure capacity used up |

## Verification
Clean words, table hits and misses with a full table are all due one cycle after the strobe edge. The bench samples them at the next falling edge and, in that same sample, checks that `busy` stayed low. A miss that starts a column scan takes a number of cycles that depends on the position found and the table size. For this case the bench first checks that `busy` is high and no result is present at that falling edge, then polls falling edges with a bound until `out_valid` appears and checks that `busy` has fallen with it. After every result it checks one more falling edge to confirm the pulse has ended, which also catches any result produced by a strobe that was issued during `busy`.

// File: rtl/ers_pkg.sv
`timescale 1ns/1ps
package ers_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EXT  = 2'd2
  } ers_state_t;
endpackage

// File: rtl/ers_syndrome.sv
`timescale 1ns/1ps
module ers_syndrome #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 5,
  parameter logic [DATA_W*CHK_W-1:0] H_DATA = '0
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk,
  output logic [CHK_W-1:0]  syn
);
  // row j of the matrix restricted to data bits
  logic [CHK_W-1:0][DATA_W-1:0] row;

  for (genvar j = 0; j < CHK_W; j++) begin : g_row
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign row[j][i] = H_DATA[i*CHK_W + j];
    end
    assign syn[j] = (^(data & row[j])) ^ chk[j];
  end
endmodule

// File: rtl/ers_table.sv
`timescale 1ns/1ps
module ers_table #(
  parameter int DATA_W   = 8,
  parameter int CHK_W    = 5,
  parameter int MAX_ERAS = 3,
  parameter int POS_W    = 4,
  parameter int CNT_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHK_W-1:0]    look_syn,
  output logic                hit,
  output logic [DATA_W-1:0]   hit_mask,
  output logic [CNT_W-1:0]    cnt,
  output logic                full,
  input  logic                ext_we,
  input  logic [MAX_ERAS-1:0] ext_k,
  input  logic [CHK_W-1:0]    ext_col,
  input  logic                commit,
  input  logic [POS_W-1:0]    commit_pos
);
  localparam int TAB_N  = 1 << MAX_ERAS;
  localparam int SLOT_W = (MAX_ERAS > 1) ? $clog2(MAX_ERAS) : 1;

  logic [CHK_W-1:0]    tab  [TAB_N];
  logic [POS_W-1:0]    slot [MAX_ERAS];
  logic [CNT_W-1:0]    cnt_q;
  logic [MAX_ERAS-1:0] wr_idx;
  logic [CHK_W-1:0]    wr_syn;
  logic [MAX_ERAS-1:0] hit_idx;

  // new entry: an old combination plus the new column
  always_comb begin
    wr_idx = ext_k | MAX_ERAS'(1 << cnt_q);
    wr_syn = tab[ext_k] ^ ext_col;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAB_N; k++) tab[k] <= '0;
      for (int j = 0; j < MAX_ERAS; j++) slot[j] <= '0;
      cnt_q <= '0;
    end else begin
      if (ext_we) tab[wr_idx] <= wr_syn;
      if (commit) begin
        slot[cnt_q[SLOT_W-1:0]] <= commit_pos;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // lowest matching combination among the live entries
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = TAB_N - 1; k >= 1; k--) begin
      if ((k < (1 << cnt_q)) && (tab[k] == look_syn)) begin
        hit     = 1'b1;
        hit_idx = MAX_ERAS'(k);
      end
    end
    hit_mask = '0;
    for (int i = 0; i < DATA_W; i++) begin
      for (int j = 0; j < MAX_ERAS; j++) begin
        if (hit_idx[j] && (slot[j] == POS_W'(i))) hit_mask[i] = 1'b1;
      end
    end
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == CNT_W'(MAX_ERAS));
endmodule

// File: rtl/ers_ctrl.sv
`timescale 1ns/1ps
module ers_ctrl
  import ers_pkg::*;
#(
  parameter int N        = 13,
  parameter int MAX_ERAS = 3,
  parameter int POS_W    = 4,
  parameter int CNT_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                scan_match,
  input  logic [CNT_W-1:0]    cnt,
  output logic                busy,
  output logic [POS_W-1:0]    scan_pos,
  output logic                ext_we,
  output logic [MAX_ERAS-1:0] ext_k,
  output logic                commit,
  output logic                fail
);
  ers_state_t          state_q, state_d;
  logic [POS_W-1:0]    pos_q, pos_d;
  logic [MAX_ERAS-1:0] k_q, k_d;
  logic [MAX_ERAS-1:0] k_lim;

  assign k_lim = MAX_ERAS'((1 << cnt) - 1);

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    k_d     = k_q;
    ext_we  = 1'b0;
    commit  = 1'b0;
    fail    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SCAN;
          pos_d   = '0;
        end
      end
      ST_SCAN: begin
        if (scan_match) begin
          state_d = ST_EXT;
          k_d     = '0;
        end else if (pos_q == POS_W'(N - 1)) begin
          state_d = ST_IDLE;
          fail    = 1'b1;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      ST_EXT: begin
        ext_we = 1'b1;
        if (k_q == k_lim) begin
          state_d = ST_IDLE;
          commit  = 1'b1;
        end else begin
          k_d = k_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      k_q     <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      k_q     <= k_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign scan_pos = pos_q;
  assign ext_k    = k_q;
endmodule

// File: rtl/ers_decoder.sv
`timescale 1ns/1ps
module ers_decoder #(
  parameter int DATA_W   = 8,
  parameter int CHK_W    = 5,
  parameter int MAX_ERAS = 3,
  parameter logic [DATA_W*CHK_W-1:0] H_DATA =
    {5'h19, 5'h16, 5'h15, 5'h13, 5'h0E, 5'h0D, 5'h0B, 5'h07}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fixed,
  output logic              out_uncorr,
  output logic              busy,
  output logic              full
);
  localparam int N     = DATA_W + CHK_W;
  localparam int POS_W = $clog2(N);
  localparam int CNT_W = $clog2(MAX_ERAS + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_int = rst_q[1];

  // matrix columns for every codeword position
  logic [N-1:0][CHK_W-1:0] cols;
  for (genvar p = 0; p < N; p++) begin : g_col
    if (p < DATA_W) begin : g_dat
      assign cols[p] = H_DATA[p*CHK_W +: CHK_W];
    end else begin : g_chk
      assign cols[p] = CHK_W'(1) << (p - DATA_W);
    end
  end

  logic [CHK_W-1:0]    rd_syn;
  logic                syn_zero;
  logic                tab_hit;
  logic [DATA_W-1:0]   hit_mask;
  logic [CNT_W-1:0]    tab_cnt;
  logic                accept;
  logic                start;
  logic                scan_match;
  logic [POS_W-1:0]    scan_pos;
  logic                ext_we;
  logic [MAX_ERAS-1:0] ext_k;
  logic                commit;
  logic                fail;
  logic [DATA_W-1:0]   hold_data;
  logic [CHK_W-1:0]    hold_syn;
  logic [DATA_W-1:0]   pos_mask;

  ers_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W), .H_DATA(H_DATA)) u_syn (
    .data (rd_data),
    .chk  (rd_chk),
    .syn  (rd_syn)
  );

  ers_table #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .MAX_ERAS(MAX_ERAS),
    .POS_W(POS_W), .CNT_W(CNT_W)
  ) u_tab (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .look_syn   (rd_syn),
    .hit        (tab_hit),
    .hit_mask   (hit_mask),
    .cnt        (tab_cnt),
    .full       (full),
    .ext_we     (ext_we),
    .ext_k      (ext_k),
    .ext_col    (cols[scan_pos]),
    .commit     (commit),
    .commit_pos (scan_pos)
  );

  ers_ctrl #(.N(N), .MAX_ERAS(MAX_ERAS), .POS_W(POS_W), .CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (start),
    .scan_match (scan_match),
    .cnt        (tab_cnt),
    .busy       (busy),
    .scan_pos   (scan_pos),
    .ext_we     (ext_we),
    .ext_k      (ext_k),
    .commit     (commit),
    .fail       (fail)
  );

  assign syn_zero   = (rd_syn == '0);
  assign accept     = rd_en & ~busy;
  assign start      = accept & ~syn_zero & ~tab_hit & ~full;
  assign scan_match = (cols[scan_pos] == hold_syn);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) pos_mask[i] = (scan_pos == POS_W'(i));
  end

  // word held while a new erasure is located
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      hold_data <= '0;
      hold_syn  <= '0;
    end else if (start) begin
      hold_data <= rd_data;
      hold_syn  <= rd_syn;
    end
  end

  logic              valid_d;
  logic [DATA_W-1:0] data_d;
  logic              fixed_d;
  logic              uncorr_d;

  always_comb begin
    valid_d  = 1'b0;
    data_d   = rd_data;
    fixed_d  = 1'b0;
    uncorr_d = 1'b0;
    if (accept && syn_zero) begin
      valid_d = 1'b1;
    end else if (accept && tab_hit) begin
      valid_d = 1'b1;
      data_d  = rd_data ^ hit_mask;
      fixed_d = 1'b1;
    end else if (accept && full) begin
      valid_d  = 1'b1;
      uncorr_d = 1'b1;
    end else if (commit) begin
      valid_d = 1'b1;
      data_d  = hold_data ^ pos_mask;
      fixed_d = 1'b1;
    end else if (fail) begin
      valid_d  = 1'b1;
      data_d   = hold_data;
      uncorr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_fixed  <= 1'b0;
      out_uncorr <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      out_fixed  <= fixed_d;
      out_uncorr <= uncorr_d;
      if (valid_d) out_data <= data_d;
    end
  end
endmodule

// File: rtl/ers_decoder_chk.sv
`timescale 1ns/1ps
module ers_decoder_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             busy,
  input logic             out_valid,
  input logic             out_fixed,
  input logic             out_uncorr,
  input logic             full,
  input logic             syn_zero,
  input logic             tab_hit,
  input logic [CNT_W-1:0] tab_cnt
);
  p_clean_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy && syn_zero) |=> (out_valid && !out_fixed && !out_uncorr));

  p_hit_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy && !syn_zero && tab_hit) |=> (out_valid && out_fixed));

  p_miss_goes_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy && !syn_zero && !tab_hit && !full) |=> (busy && !out_valid));

  p_count_never_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tab_cnt >= $past(tab_cnt));

  p_full_miss_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy && !syn_zero && !tab_hit && full) |=> (out_valid && out_uncorr && !busy));

  p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  p_no_result_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid);

  p_result_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(rd_en && !busy) || $past(busy)));

  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_fixed && out_uncorr));
endmodule

bind ers_decoder ers_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .rd_en      (rd_en),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_fixed  (out_fixed),
  .out_uncorr (out_uncorr),
  .full       (full),
  .syn_zero   (syn_zero),
  .tab_hit    (tab_hit),
  .tab_cnt    (tab_cnt)
);

// File: tb/sim_ers_decoder.sv
`timescale 1ns/1ps
module sim_ers_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data = '0;
  logic [4:0] rd_chk = '0;
  logic       out_valid, out_fixed, out_uncorr, busy, full;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int eras [3];
  int n_eras = 0;

  always #10 clk = ~clk;

  ers_decoder u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_chk(rd_chk),
    .out_valid(out_valid), .out_data(out_data), .out_fixed(out_fixed),
    .out_uncorr(out_uncorr), .busy(busy), .full(full)
  );

  // R1: column of each codeword position
  function automatic logic [4:0] col(input int p);
    case (p)
      0: return 5'h07;
      1: return 5'h0B;
      2: return 5'h0D;
      3: return 5'h0E;
      4: return 5'h13;
      5: return 5'h15;
      6: return 5'h16;
      7: return 5'h19;
      default: return 5'(1) << (p - 8);
    endcase
  endfunction

  function automatic logic [4:0] enc(input logic [7:0] d);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) if (d[i]) r ^= col(i);
    return r;
  endfunction

  task automatic flip(inout logic [7:0] d, inout logic [4:0] c, input int p);
    if (p < 8) d[p] = ~d[p];
    else       c[p-8] = ~c[p-8];
  endtask

  task automatic check(input longint act, input longint exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // kind: 0 clean, 1 table hit, 2 learn, 3 full miss, 4 scan fails
  task automatic expect_of(input logic [7:0] d, input logic [4:0] c,
                           output int kind, output logic [7:0] ed, output int npos);
    logic [4:0] s;
    s = enc(d) ^ c;
    kind = 4; ed = d; npos = -1;
    if (s == 0) begin kind = 0; return; end
    for (int m = 1; m < (1 << n_eras); m++) begin
      logic [4:0] acc;
      logic [7:0] fl;
      acc = '0; fl = '0;
      for (int j = 0; j < n_eras; j++) begin
        if (m[j]) begin
          acc ^= col(eras[j]);
          if (eras[j] < 8) fl[eras[j]] = 1'b1;
        end
      end
      if (acc == s) begin kind = 1; ed = d ^ fl; return; end
    end
    if (n_eras == 3) begin kind = 3; return; end
    for (int p = 0; p < 13; p++) begin
      if (col(p) == s) begin
        kind = 2; npos = p;
        if (p < 8) ed = d ^ (8'd1 << p);
        return;
      end
    end
  endtask

  task automatic do_read(input logic [7:0] d, input logic [4:0] c, input string tag, input bit poke);
    int kind, npos, guard;
    logic [7:0] ed;
    expect_of(d, c, kind, ed, npos);
    @(negedge clk);
    rd_en = 1'b1; rd_data = d; rd_chk = c;
    @(negedge clk);
    rd_en = 1'b0;
    if (kind == 0 || kind == 1 || kind == 3) begin
      check(out_valid, 1, tag, "valid one cycle after strobe");
      check(out_data, ed, tag, "data");
      check(out_fixed, kind == 1, tag, "fixed flag");
      check(out_uncorr, kind == 3, tag, "uncorrectable flag");
      check(busy, 0, tag, "busy stays low");
    end else begin
      check(out_valid, 0, tag, "no result at first cycle of scan");
      check(busy, 1, tag, "busy after unmatched syndrome");
      if (poke) begin
        // R7: strobe during busy must not be taken
        rd_en = 1'b1; rd_data = 8'h5A; rd_chk = enc(8'h5A);
        @(negedge clk);
        rd_en = 1'b0;
      end
      guard = 0;
      while (!out_valid && guard < 64) begin
        @(negedge clk);
        guard++;
      end
      check(out_valid, 1, tag, "result when busy falls");
      check(busy, 0, tag, "busy low with result");
      check(out_data, ed, tag, "data after scan");
      check(out_fixed, kind == 2, tag, "fixed flag after scan");
      check(out_uncorr, kind == 4, tag, "uncorrectable flag after scan");
      if (kind == 2) begin eras[n_eras] = npos; n_eras++; end
    end
    @(negedge clk);
    check(out_valid, 0, "R7", "single result pulse");
    check(full, n_eras == 3, "R6", "full flag");
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [4:0] c;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(out_valid, 0, "R8", "valid in reset");
    check(busy, 0, "R8", "busy in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid, 0, "R8", "valid after reset");
    check(busy, 0, "R8", "busy after reset");
    check(full, 0, "R8", "full after reset");

    // R2 and R1: clean words
    d = 8'hA5; c = enc(d); do_read(d, c, "R2", 0);
    d = 8'h00; c = enc(d); do_read(d, c, "R1", 0);

    // R4: learn data bit 3
    d = 8'h3C; c = enc(d); flip(d, c, 3); do_read(d, c, "R4", 0);
    // R3: same error now a hit
    d = 8'hC3; c = enc(d); flip(d, c, 3); do_read(d, c, "R3", 0);

    // R5: bits 3 and 10 together match nothing
    d = 8'h96; c = enc(d); flip(d, c, 3); flip(d, c, 10); do_read(d, c, "R5", 0);
    // R5: table unchanged, so bit 10 alone still needs learning
    d = 8'h11; c = enc(d); flip(d, c, 10); do_read(d, c, "R5", 0);

    // R4/R7: learn bit 5 with a strobe poked during busy
    d = 8'hF0; c = enc(d); flip(d, c, 5); do_read(d, c, "R7", 1);

    // R9: all three stored positions wrong at once
    d = 8'h7E; c = enc(d); flip(d, c, 3); flip(d, c, 5); flip(d, c, 10); do_read(d, c, "R9", 0);
    // R6: new failure with table full
    d = 8'h81; c = enc(d); flip(d, c, 0); do_read(d, c, "R6", 0);

    // R9/R3: random words over the stored positions, some with a stray flip
    for (int it = 0; it < 200; it++) begin
      int sel;
      d = 8'($urandom); c = enc(d);
      sel = int'($urandom % 8);
      for (int j = 0; j < 3; j++) if (sel[j]) flip(d, c, eras[j]);
      if ($urandom % 8 == 0) flip(d, c, int'($urandom % 13));
      do_read(d, c, "R9", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule